// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block takes an interrupt command, split into a lower and an upper 32-bit word, and a table of `N_TGT` target descriptors. It works out which targets the command addresses and then drives one-cycle delivery strobes to those targets, chosen by the delivery mode. Each descriptor carries three fields:

- an 8-bit physical ID;
- an 8-bit logical destination byte;
- a 4-bit addressing-model nibble.

Targets can be addressed in three ways: by physical ID, through flat logical matching, or through clustered logical matching. Shorthands can instead name the sender alone, every target, or every target except the sender.

The block is a two-state machine. `ST_IDLE` waits for a command, and `ST_FIRE` is the single cycle in which outputs are driven. The transitions are:

- `ST_IDLE -> ST_FIRE` when `cmd_valid` is high.
- `ST_FIRE -> ST_FIRE` when another command arrives back to back.
- `ST_FIRE -> ST_IDLE` when `cmd_valid` is low.

The resolved set is captured on the same edge that enters `ST_FIRE`. Lowest-priority delivery is reduced to picking the lowest-indexed selected target. There is no priority arbitration.

Top module: `ipi_route_top`

## Requirements
- R1: Every output except `sipi_vector` is zero after reset and in any cycle not directly after a `cmd_valid` cycle. A command sampled with `cmd_valid` high at edge k drives its outputs for exactly the cycle after edge k. Back-to-back commands each get their own cycle.
- R2: The shorthand field `cmd_lo[19:18]` selects the target set as follows:
  - 1 selects only target `sender_idx`;
  - 2 selects every target;
  - 3 selects every target except `sender_idx`;
  - 0 uses destination addressing.
- R3: With shorthand 0 and `cmd_lo[11]`=0 (physical addressing), the destination is `cmd_hi[31:24]`. A destination of 0xFF selects every target. Any other value selects only the lowest-indexed target whose physical ID equals it, or no target if none does.
- R4: With shorthand 0 and `cmd_lo[11]`=1 (logical addressing), a target whose model nibble is 0xF matches when the destination AND its logical byte is nonzero.
- R5: In logical addressing, a target with model 0x0 matches when the destination's upper nibble equals the upper nibble of its logical byte and the two lower nibbles share a set bit. Targets with any other model never match.
- R6: Delivery mode `cmd_lo[10:8]`=0 (fixed) pulses `fixed_irq` on every selected target. In the same cycle, `irq_vector` shows `cmd_lo[7:0]` and `irq_trig` shows `cmd_lo[15]`.
- R7: Delivery mode 1 (lowest priority) pulses `fixed_irq` only on the lowest-indexed selected target, with the same vector and trigger as R6, and pulses nothing when the set is empty.
- R8: Delivery mode 2 pulses `smi_pulse` on every selected target, and mode 4 does the same on `nmi_pulse`.
- R9: Delivery mode 5 pulses `init_pulse` on every selected target, except when `cmd_lo[14]`=0 and `cmd_lo[15]`=1. In that de-assert case, `init_pulse` stays zero and `arb_reload` pulses on every selected target instead.
- R10: Delivery mode 6 (startup) pulses `sipi_pulse` on every selected target. From the same edge, it stores `cmd_lo[7:0]` in the 8-bit slice i of `sipi_vector` for each selected target i. Unselected slices keep their value, and all slices reset to zero.
- R11: Delivery modes 3 and 7 pulse nothing, while `target_mask` still reports the resolved set.
- R12: For modes 0 through 7 alike, `target_mask` shows the resolved set during the output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_lo | input | 32 | Lower command word: vector, mode, addressing, level, trigger, shorthand |
| cmd_hi | input | 32 | Upper command word; destination in bits 31:24 |
| sender_idx | input | $clog2(N_TGT) | Index of the issuing target |
| tgt_phys_id | input | N_TGT*8 | Physical ID per target |
| tgt_log_dest | input | N_TGT*8 | Logical destination byte per target |
| tgt_model | input | N_TGT*4 | Addressing model nibble per target |
| target_mask | output | N_TGT | Resolved target set in the output cycle |
| fixed_irq | output | N_TGT | Vectored interrupt strobe per target |
| irq_vector | output | 8 | Vector for `fixed_irq` |
| irq_trig | output | 1 | Trigger mode for `fixed_irq` |
| smi_pulse | output | N_TGT | System-management interrupt strobe |
| nmi_pulse | output | N_TGT | Non-maskable interrupt strobe |
| init_pulse | output | N_TGT | INIT strobe |
| arb_reload | output | N_TGT | Arbitration-ID reload strobe (INIT de-assert) |
| sipi_pulse | output | N_TGT | Startup strobe |
| sipi_vector | output | N_TGT*8 | Stored startup vector per target |

## Verification
A corrupted capture register or a wrong machine state shows up in the very next cycle. It appears as a strobe on the wrong target or on the wrong strobe line, or as a strobe in a cycle with no command before it. The bench sweeps every destination byte under two descriptor tables, one flat with a duplicated physical ID and one clustered with a flat and an unmatched model. It also walks every mode, shorthand and sender back to back, so a mismatch surfaces one cycle after the command that caused it. A wrong startup-vector slice stays visible on `sipi_vector` until the next startup command, and the bench compares that output after every command.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;

    localparam int DEST_W  = 8;
    localparam int MODEL_W = 4;
    localparam int VEC_W   = 8;
    localparam int WORD_W  = 32;

    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_RSV7   = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } rstate_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        dmode_e            mode;
        logic              logical;
        logic              level;
        logic              trig;
        shorthand_e        sh;
        logic [DEST_W-1:0] dest;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] lo,
                                        input logic [WORD_W-1:0] hi);
        cmd_t c;
        c.vector  = lo[7:0];
        c.mode    = dmode_e'(lo[10:8]);
        c.logical = lo[11];
        c.level   = lo[14];
        c.trig    = lo[15];
        c.sh      = shorthand_e'(lo[19:18]);
        c.dest    = hi[31:24];
        return c;
    endfunction

endpackage

// File: rtl/ipi_tgt_match.sv
module ipi_tgt_match
    import ipi_route_pkg::*;
#(
    parameter int N_TGT = 8
) (
    input  logic [DEST_W-1:0]        dest,
    input  logic [N_TGT*DEST_W-1:0]  phys_id,
    input  logic [N_TGT*DEST_W-1:0]  log_dest,
    input  logic [N_TGT*MODEL_W-1:0] model,
    output logic [N_TGT-1:0]         phys_hit,
    output logic [N_TGT-1:0]         log_hit
);

    localparam int NIB = DEST_W / 2;

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        logic [DEST_W-1:0]  id_g;
        logic [DEST_W-1:0]  ld_g;
        logic [MODEL_W-1:0] md_g;
        logic               flat_g;
        logic               clus_g;

        assign id_g = phys_id[g*DEST_W +: DEST_W];
        assign ld_g = log_dest[g*DEST_W +: DEST_W];
        assign md_g = model[g*MODEL_W +: MODEL_W];

        assign flat_g = (md_g == MODEL_FLAT) && (|(dest & ld_g));
        assign clus_g = (md_g == MODEL_CLUSTER)
                     && (dest[DEST_W-1:NIB] == ld_g[DEST_W-1:NIB])
                     && (|(dest[NIB-1:0] & ld_g[NIB-1:0]));

        assign phys_hit[g] = (id_g == dest);
        assign log_hit[g]  = flat_g | clus_g;
    end

endmodule

// File: rtl/ipi_dest_set.sv
module ipi_dest_set
    import ipi_route_pkg::*;
#(
    parameter int N_TGT = 8
) (
    input  shorthand_e               sh,
    input  logic                     logical,
    input  logic [DEST_W-1:0]        dest,
    input  logic [N_TGT-1:0]         phys_hit,
    input  logic [N_TGT-1:0]         log_hit,
    input  logic [$clog2(N_TGT)-1:0] sender,
    output logic [N_TGT-1:0]         sel
);

    logic [N_TGT-1:0] all_bits;
    logic [N_TGT-1:0] self_bit;
    logic [N_TGT-1:0] addressed;

    assign all_bits = '1;
    assign self_bit = N_TGT'(1) << sender;

    always_comb begin
        if (logical) begin
            addressed = log_hit;
        end else if (dest == '1) begin
            addressed = all_bits;
        end else begin
            addressed = phys_hit & (~phys_hit + N_TGT'(1));
        end
    end

    always_comb begin
        unique case (sh)
            SH_NONE:   sel = addressed;
            SH_SELF:   sel = self_bit;
            SH_ALL:    sel = all_bits;
            SH_OTHERS: sel = all_bits & ~self_bit;
        endcase
    end

endmodule

// File: rtl/ipi_route_top.sv
module ipi_route_top
    import ipi_route_pkg::*;
#(
    parameter int N_TGT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [31:0]                cmd_lo,
    input  logic [31:0]                cmd_hi,
    input  logic [$clog2(N_TGT)-1:0]   sender_idx,
    input  logic [N_TGT*8-1:0]         tgt_phys_id,
    input  logic [N_TGT*8-1:0]         tgt_log_dest,
    input  logic [N_TGT*4-1:0]         tgt_model,
    output logic [N_TGT-1:0]           target_mask,
    output logic [N_TGT-1:0]           fixed_irq,
    output logic [7:0]                 irq_vector,
    output logic                       irq_trig,
    output logic [N_TGT-1:0]           smi_pulse,
    output logic [N_TGT-1:0]           nmi_pulse,
    output logic [N_TGT-1:0]           init_pulse,
    output logic [N_TGT-1:0]           arb_reload,
    output logic [N_TGT-1:0]           sipi_pulse,
    output logic [N_TGT*8-1:0]         sipi_vector
);

    cmd_t             cmd;
    logic [N_TGT-1:0] phys_hit;
    logic [N_TGT-1:0] log_hit;
    logic [N_TGT-1:0] sel_now;

    rstate_e          state_q;
    rstate_e          state_d;
    logic [N_TGT-1:0] mask_q;
    logic [VEC_W-1:0] vec_q;
    logic             trig_q;
    logic             deassert_q;
    dmode_e           mode_q;
    logic [N_TGT*VEC_W-1:0] svec_q;

    assign cmd = decode_cmd(cmd_lo, cmd_hi);

    ipi_tgt_match #(.N_TGT(N_TGT)) match_i (
        .dest     (cmd.dest),
        .phys_id  (tgt_phys_id),
        .log_dest (tgt_log_dest),
        .model    (tgt_model),
        .phys_hit (phys_hit),
        .log_hit  (log_hit)
    );

    ipi_dest_set #(.N_TGT(N_TGT)) set_i (
        .sh       (cmd.sh),
        .logical  (cmd.logical),
        .dest     (cmd.dest),
        .phys_hit (phys_hit),
        .log_hit  (log_hit),
        .sender   (sender_idx),
        .sel      (sel_now)
    );

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = cmd_valid ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = cmd_valid ? ST_FIRE : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '0;
            vec_q      <= '0;
            trig_q     <= 1'b0;
            deassert_q <= 1'b0;
            mode_q     <= DM_FIXED;
        end else if (cmd_valid) begin
            mask_q     <= sel_now;
            vec_q      <= cmd.vector;
            trig_q     <= cmd.trig;
            deassert_q <= !cmd.level && cmd.trig;
            mode_q     <= cmd.mode;
        end
    end

    // Per-target startup vector storage
    for (genvar g = 0; g < N_TGT; g++) begin : g_svec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                svec_q[g*VEC_W +: VEC_W] <= '0;
            end else if (cmd_valid && cmd.mode == DM_START && sel_now[g]) begin
                svec_q[g*VEC_W +: VEC_W] <= cmd.vector;
            end
        end
    end

    assign sipi_vector = svec_q;

    // Outputs
    always_comb begin
        target_mask = '0;
        fixed_irq   = '0;
        irq_vector  = '0;
        irq_trig    = 1'b0;
        smi_pulse   = '0;
        nmi_pulse   = '0;
        init_pulse  = '0;
        arb_reload  = '0;
        sipi_pulse  = '0;
        if (state_q == ST_FIRE) begin
            target_mask = mask_q;
            irq_vector  = vec_q;
            irq_trig    = trig_q;
            unique case (mode_q)
                DM_FIXED:  fixed_irq = mask_q;
                DM_LOWEST: fixed_irq = mask_q & (~mask_q + N_TGT'(1));
                DM_SMI:    smi_pulse = mask_q;
                DM_NMI:    nmi_pulse = mask_q;
                DM_INIT: begin
                    if (deassert_q) arb_reload = mask_q;
                    else            init_pulse = mask_q;
                end
                DM_START:  sipi_pulse = mask_q;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/ipi_route_chk.sv
module ipi_route_chk #(
    parameter int N_TGT = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [31:0]              cmd_lo,
    input logic [31:0]              cmd_hi,
    input logic [$clog2(N_TGT)-1:0] sender_idx,
    input logic [N_TGT-1:0]         target_mask,
    input logic [N_TGT-1:0]         fixed_irq,
    input logic [7:0]               irq_vector,
    input logic                     irq_trig,
    input logic [N_TGT-1:0]         smi_pulse,
    input logic [N_TGT-1:0]         nmi_pulse,
    input logic [N_TGT-1:0]         init_pulse,
    input logic [N_TGT-1:0]         arb_reload,
    input logic [N_TGT-1:0]         sipi_pulse
);

    logic [N_TGT-1:0] any_pulse;
    assign any_pulse = fixed_irq | smi_pulse | nmi_pulse | init_pulse
                     | arb_reload | sipi_pulse;

    // R1: quiet after a cycle without a command
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (any_pulse == '0) && (target_mask == '0));

    // R2: self shorthand selects only the sender
    p_self_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[19:18] == 2'd1)
        |=> target_mask == (N_TGT'(1) << $past(sender_idx)));

    // R2: all-but-self shorthand
    p_others_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[19:18] == 2'd3)
        |=> !target_mask[$past(sender_idx)] && ($countones(target_mask) == N_TGT - 1));

    // R3: physical broadcast
    p_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[19:18] == 2'd0 && !cmd_lo[11] && cmd_hi[31:24] == 8'hFF)
        |=> target_mask == '1);

    // R6: fixed delivery reaches the whole set with the command's vector
    p_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[10:8] == 3'd0)
        |=> (fixed_irq == target_mask) && (irq_vector == $past(cmd_lo[7:0]))
            && (irq_trig == $past(cmd_lo[15])));

    // R7: lowest priority reaches at most one selected target
    p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[10:8] == 3'd1)
        |=> $onehot0(fixed_irq) && ((fixed_irq & ~target_mask) == '0)
            && ((target_mask != '0) == (fixed_irq != '0)));

    // R9: INIT de-assert reloads arbitration IDs only
    p_init_deassert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[10:8] == 3'd5 && !cmd_lo[14] && cmd_lo[15])
        |=> (init_pulse == '0) && (arb_reload == target_mask));

    // R10: startup strobes the whole set
    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[10:8] == 3'd6)
        |=> sipi_pulse == target_mask);

    // R11: reserved modes deliver nothing
    p_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_lo[10:8] == 3'd3 || cmd_lo[10:8] == 3'd7))
        |=> any_pulse == '0);

endmodule

bind ipi_route_top ipi_route_chk #(.N_TGT(N_TGT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_lo      (cmd_lo),
    .cmd_hi      (cmd_hi),
    .sender_idx  (sender_idx),
    .target_mask (target_mask),
    .fixed_irq   (fixed_irq),
    .irq_vector  (irq_vector),
    .irq_trig    (irq_trig),
    .smi_pulse   (smi_pulse),
    .nmi_pulse   (nmi_pulse),
    .init_pulse  (init_pulse),
    .arb_reload  (arb_reload),
    .sipi_pulse  (sipi_pulse)
);

// File: tb/ipi_route_top_tb_top.sv
`timescale 1ns/1ps
module ipi_route_top_tb_top;

    localparam int N = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [31:0]      cmd_lo = '0;
    logic [31:0]      cmd_hi = '0;
    logic [2:0]       sender_idx = '0;
    logic [N*8-1:0]   tgt_phys_id = '0;
    logic [N*8-1:0]   tgt_log_dest = '0;
    logic [N*4-1:0]   tgt_model = '0;
    logic [N-1:0]     target_mask, fixed_irq, smi_pulse, nmi_pulse;
    logic [N-1:0]     init_pulse, arb_reload, sipi_pulse;
    logic [7:0]       irq_vector;
    logic             irq_trig;
    logic [N*8-1:0]   sipi_vector;

    int errors = 0;
    int checks = 0;

    logic [7:0] t_id [N];
    logic [7:0] t_ld [N];
    logic [3:0] t_md [N];
    logic [7:0] exp_sv [N];

    always #2.5 clk = ~clk;

    ipi_route_top #(.N_TGT(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .sender_idx(sender_idx),
        .tgt_phys_id(tgt_phys_id), .tgt_log_dest(tgt_log_dest),
        .tgt_model(tgt_model), .target_mask(target_mask),
        .fixed_irq(fixed_irq), .irq_vector(irq_vector), .irq_trig(irq_trig),
        .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse),
        .init_pulse(init_pulse), .arb_reload(arb_reload),
        .sipi_pulse(sipi_pulse), .sipi_vector(sipi_vector)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic load_table(input int kind);
        for (int i = 0; i < N; i++) begin
            if (kind == 0) begin
                t_id[i] = 8'(i * 3 + 1);
                t_ld[i] = 8'(1 << i);
                t_md[i] = 4'hF;
            end else begin
                t_id[i] = 8'(8'h40 + i);
                t_ld[i] = {4'(i / 2 + 1), 4'(1 << (i % 4))};
                t_md[i] = (i == 6) ? 4'hF : ((i == 7) ? 4'h5 : 4'h0);
            end
        end
        if (kind == 0) t_id[5] = t_id[2];   // duplicate physical ID
        for (int i = 0; i < N; i++) begin
            tgt_phys_id[i*8 +: 8]  = t_id[i];
            tgt_log_dest[i*8 +: 8] = t_ld[i];
            tgt_model[i*4 +: 4]    = t_md[i];
        end
    endtask

    function automatic logic [31:0] mk_lo(input logic [7:0] v, input logic [2:0] m,
                                          input logic lg, input logic lv,
                                          input logic tr, input logic [1:0] sh);
        logic [31:0] w;
        w = '0;
        w[7:0] = v; w[10:8] = m; w[11] = lg; w[14] = lv; w[15] = tr; w[19:18] = sh;
        return w;
    endfunction

    function automatic logic [N-1:0] exp_set(input logic [31:0] lo,
                                             input logic [7:0] d, input int snd);
        logic [N-1:0] s;
        s = '0;
        case (lo[19:18])
            2'd1: s[snd] = 1'b1;
            2'd2: s = '1;
            2'd3: begin s = '1; s[snd] = 1'b0; end
            default: begin
                if (!lo[11]) begin
                    if (d == 8'hFF) s = '1;
                    else begin
                        for (int i = N - 1; i >= 0; i--)
                            if (t_id[i] == d) s = N'(1) << i;
                    end
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (t_md[i] == 4'hF && (d & t_ld[i]) != 0) s[i] = 1'b1;
                        if (t_md[i] == 4'h0 && d[7:4] == t_ld[i][7:4]
                            && (d[3:0] & t_ld[i][3:0]) != 0) s[i] = 1'b1;
                    end
                end
            end
        endcase
        return s;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R6";
            3'd1: return "R7";
            3'd2, 3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check_idle(input string what);
        chk({target_mask, fixed_irq, smi_pulse, nmi_pulse, init_pulse, arb_reload,
             sipi_pulse, irq_vector, irq_trig} == '0, "R1", what,
            {fixed_irq, smi_pulse, nmi_pulse, init_pulse, arb_reload, sipi_pulse},
            64'h0);
    endtask

    task automatic issue(input logic [31:0] lo, input logic [7:0] d,
                         input int snd, input bit hold);
        logic [N-1:0] em, lowest, efix, esmi, enmi, einit, erel, esipi;
        logic [N*8-1:0] esv;
        logic [2:0] m;
        string mtag;
        cmd_lo = lo; cmd_hi = {d, 24'h0}; sender_idx = 3'(snd); cmd_valid = 1'b1;
        em = exp_set(lo, d, snd);
        m  = lo[10:8];
        lowest = '0;
        for (int i = N - 1; i >= 0; i--) if (em[i]) lowest = N'(1) << i;
        efix = '0; esmi = '0; enmi = '0; einit = '0; erel = '0; esipi = '0;
        case (m)
            3'd0: efix = em;
            3'd1: efix = lowest;
            3'd2: esmi = em;
            3'd4: enmi = em;
            3'd5: if (!lo[14] && lo[15]) erel = em; else einit = em;
            3'd6: begin
                esipi = em;
                for (int i = 0; i < N; i++) if (em[i]) exp_sv[i] = lo[7:0];
            end
            default: ;
        endcase
        for (int i = 0; i < N; i++) esv[i*8 +: 8] = exp_sv[i];
        @(negedge clk);
        mtag = mode_tag(m);
        if (lo[19:18] != 2'd0)
            chk(target_mask == em, "R2 R12", "mask", 64'(target_mask), 64'(em));
        else if (!lo[11])
            chk(target_mask == em, "R3 R12", "mask", 64'(target_mask), 64'(em));
        else
            chk(target_mask == em, "R4 R5 R12", "mask", 64'(target_mask), 64'(em));
        chk({fixed_irq, smi_pulse, nmi_pulse, init_pulse, arb_reload, sipi_pulse}
            == {efix, esmi, enmi, einit, erel, esipi}, mtag, "pulses",
            64'({fixed_irq, smi_pulse, nmi_pulse, init_pulse, arb_reload, sipi_pulse}),
            64'({efix, esmi, enmi, einit, erel, esipi}));
        if (m == 3'd0 || m == 3'd1)
            chk({irq_vector, irq_trig} == {lo[7:0], lo[15]}, "R6", "vector/trig",
                64'({irq_vector, irq_trig}), 64'({lo[7:0], lo[15]}));
        chk(sipi_vector == esv, "R10", "startup vectors",
            sipi_vector, esv);
        if (!hold) cmd_valid = 1'b0;
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish act=0 exp=1");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) exp_sv[i] = '0;
        load_table(0);
        repeat (3) @(negedge clk);
        // R1 and R10: reset state
        check_idle("reset outputs");
        chk(sipi_vector == '0, "R10", "reset startup vectors", sipi_vector, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table 0: flat logical targets, duplicated physical ID
        for (int d = 0; d < 256; d++)
            issue(mk_lo(8'(d), 3'd0, 1'b0, 1'b1, d[0], 2'd0), 8'(d), 0, 1'b0);
        @(negedge clk);
        check_idle("after physical sweep");
        for (int d = 0; d < 256; d++)
            issue(mk_lo(8'(d), 3'd1, 1'b1, 1'b1, d[1], 2'd0), 8'(d), d % N, 1'b0);
        @(negedge clk);
        check_idle("after lowest sweep");

        // Table 1: clustered targets, one flat, one unmatched model
        load_table(1);
        for (int d = 0; d < 256; d++)
            issue(mk_lo(8'(255 - d), d[0] ? 3'd4 : 3'd2, 1'b0, 1'b1, 1'b0, 2'd0),
                  8'(d), 0, 1'b0);
        for (int d = 0; d < 256; d++)
            issue(mk_lo(8'(d), 3'd0, 1'b1, 1'b1, 1'b1, 2'd0), 8'(d), 0, 1'b0);
        @(negedge clk);
        check_idle("after logical sweep");

        // Every mode x shorthand x sender, back to back
        for (int m = 0; m < 8; m++)
            for (int sh = 0; sh < 4; sh++)
                for (int s = 0; s < N; s++)
                    issue(mk_lo(8'(m * 32 + sh * 8 + s), 3'(m), m[0], sh[0], s[0], 2'(sh)),
                          8'(8'h21 + s * 17), s, 1'b1);
        cmd_valid = 1'b0;
        @(negedge clk);
        check_idle("after back-to-back run");
        @(negedge clk);
        summary();
    end

endmodule